// File: doc/BRIEF.md
# Four-Mode Timer/Counter Pair

This block holds two counter channels, each made of a low byte and a high byte, together with a shared mode byte and a shared control byte. Software loads counts, modes and run bits through a single-cycle write port and reads any of them back through a combinational read port. Each channel counts either an internal tick, which is one pulse every 12 system clocks, or falling edges on its own external event input. A per-channel gate option makes counting also depend on an external gate level.

Each channel picks one of four modes: a 13-bit count that uses only five low-byte bits, a 16-bit count, an 8-bit count that reloads itself from the high byte, and a split mode. In split mode, channel 0 becomes two independent 8-bit counters, and its high byte takes over channel 1's overflow flag. Overflow flags are set by hardware and cleared by software writes.

Top module: `tmr_quad_mode`

## Requirements
- R1: Register addresses are 0 control, 1 mode, 2 channel 0 low, 3 channel 0 high, 4 channel 1 low, 5 channel 1 high. A write lands at the clock edge where `wr_en` is high, and the new value can be read from the next cycle. Unused addresses read 0. After reset, every register reads 0.
- R2: Control byte bits 7..4 are flag 1, run 1, flag 0 and run 0. Bits 3..0 are only stored and read back. Mode byte bits 3..0 belong to channel 0 and bits 7..4 to channel 1. Within each nibble the bits are {gate, event_select, m1, m0}.
- R3: A channel counts only while its run bit is 1. If its gate bit is 1, the channel's `gate_in` must also be high. Reset clears both run bits, so no count changes while neither channel is running.
- R4: With event_select 0, a running channel advances exactly once in any 12 consecutive clock edges.
- R5: With event_select 1, a running channel advances once for each 1-to-0 transition of its `ev_in` bit. The input passes through a two-flop synchronizer, and the count changes on the third clock edge after the fall.
- R6: Mode 00 counts the 13-bit value {high[7:0], low[4:0]}. Low bits 7..5 keep their value. Going from 1FFF to 0000 sets the channel's flag.
- R7: Mode 01 counts the 16-bit value {high, low}. Going from FFFF to 0000 sets the channel's flag.
- R8: Mode 10 counts the low byte alone. On an FF overflow it sets the flag and loads the low byte from the high byte, which stays unchanged.
- R9: Channel 0 in mode 11 splits into two counters. Its low byte uses channel 0's run, gate and event_select and sets flag 0. Its high byte counts internal ticks while run 1 is set, and its FF-to-00 overflow sets flag 1.
- R10: While channel 0 is in mode 11, channel 1 still counts in modes 00, 01 and 10 but sets no flag. Channel 1 in mode 11 holds its count.
- R11: A control write loads both flags from bits 7 and 5. A hardware overflow in the same cycle wins over that write, so the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 8 | Combinational read data |
| ev_in | input | 2 | External event inputs, bit n for channel n |
| gate_in | input | 2 | External gate inputs, bit n for channel n |

## Verification
Register writes show on the read port one cycle after their write edge, and the bench reads at the following falling edge. For internal-tick counting, the run bit is set by one write and cleared by a second write that lands exactly 12*K edges later. Any such window holds exactly K ticks whatever the prescaler phase, so the expected count is K steps of the bench's arithmetic model. Event pulses are held low and high for four clocks each, and reads wait well past the three-edge synchronizer delay. The stopping write copies back the flags it has just read, so a flag raised on the final edge survives through the hardware-priority rule.

// File: rtl/tmr_quad_mode.sv
module tmr_quad_mode #(
  parameter int TICK_DIV = 12,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  input  logic [1:0]    ev_in,
  input  logic [1:0]    gate_in
);
  localparam int DW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [AW-1:0] A_CTL = AW'(0);
  localparam logic [AW-1:0] A_MOD = AW'(1);
  localparam logic [AW-1:0] A_L0  = AW'(2);
  localparam logic [AW-1:0] A_H0  = AW'(3);
  localparam logic [AW-1:0] A_L1  = AW'(4);
  localparam logic [AW-1:0] A_H1  = AW'(5);

  logic [7:0] ctl_q, mode_q, lo0, hi0, lo1, hi1;
  logic [DW-1:0] div_q;
  logic [1:0] ev_a, ev_b, ev_c;

  wire tick = (div_q == DW'(TICK_DIV - 1));
  wire [1:0] fall = ev_c & ~ev_b;
  wire [1:0] run = {ctl_q[6], ctl_q[4]};
  wire [1:0] gate_en = {mode_q[7], mode_q[3]};
  wire [1:0] csel = {mode_q[6], mode_q[2]};
  wire [1:0] m0 = mode_q[1:0];
  wire [1:0] m1 = mode_q[5:4];

  logic [1:0] step;
  for (genvar c = 0; c < 2; c++) begin : g_step
    assign step[c] = run[c] & (~gate_en[c] | gate_in[c]) & (csel[c] ? fall[c] : tick);
  end

  wire split = (m0 == 2'b11);
  wire hstep = split & ctl_q[6] & tick;

  function automatic logic [16:0] advance(input logic [1:0] m, input logic [7:0] h,
                                          input logic [7:0] l);
    logic [12:0] v13;
    logic [15:0] v16;
    logic [16:0] r;
    case (m)
      2'b00: begin
        v13 = {h, l[4:0]} + 13'd1;
        r = {&{h, l[4:0]}, v13[12:5], l[7:5], v13[4:0]};
      end
      2'b01: begin
        v16 = {h, l} + 16'd1;
        r = {&{h, l}, v16};
      end
      2'b10: r = {&l, h, (&l) ? h : l + 8'd1};
      default: r = {&l, h, l + 8'd1};
    endcase
    return r;
  endfunction

  wire [16:0] nx0 = advance(m0, hi0, lo0);
  wire [16:0] nx1 = advance(m1, hi1, lo1);

  wire ch1_go = step[1] & (m1 != 2'b11);
  wire set_f0 = step[0] & nx0[16];
  wire set_f1 = (ch1_go & nx1[16] & ~split) | (hstep & (&hi0));

  wire w_ctl = wr_en & (wr_addr == A_CTL);
  wire w_mod = wr_en & (wr_addr == A_MOD);
  wire w_l0  = wr_en & (wr_addr == A_L0);
  wire w_h0  = wr_en & (wr_addr == A_H0);
  wire w_l1  = wr_en & (wr_addr == A_L1);
  wire w_h1  = wr_en & (wr_addr == A_H1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      ev_a <= '1;
      ev_b <= '1;
      ev_c <= '1;
    end else begin
      div_q <= tick ? '0 : div_q + DW'(1);
      ev_a <= ev_in;
      ev_b <= ev_a;
      ev_c <= ev_b;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      mode_q <= '0;
    end else begin
      if (w_mod) mode_q <= wr_data;
      if (w_ctl) begin
        ctl_q[6] <= wr_data[6];
        ctl_q[4] <= wr_data[4];
        ctl_q[3:0] <= wr_data[3:0];
      end
      ctl_q[7] <= set_f1 | (w_ctl ? wr_data[7] : ctl_q[7]);
      ctl_q[5] <= set_f0 | (w_ctl ? wr_data[5] : ctl_q[5]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo0 <= '0;
      hi0 <= '0;
    end else begin
      if (w_l0) lo0 <= wr_data;
      else if (step[0]) lo0 <= nx0[7:0];
      if (w_h0) hi0 <= wr_data;
      else if (split) begin
        if (hstep) hi0 <= hi0 + 8'd1;
      end else if (step[0]) hi0 <= nx0[15:8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo1 <= '0;
      hi1 <= '0;
    end else begin
      if (w_l1) lo1 <= wr_data;
      else if (ch1_go) lo1 <= nx1[7:0];
      if (w_h1) hi1 <= wr_data;
      else if (ch1_go) hi1 <= nx1[15:8];
    end
  end

  always_comb begin
    case (rd_addr)
      A_CTL:   rd_data = ctl_q;
      A_MOD:   rd_data = mode_q;
      A_L0:    rd_data = lo0;
      A_H0:    rd_data = hi0;
      A_L1:    rd_data = lo1;
      A_H1:    rd_data = hi1;
      default: rd_data = '0;
    endcase
  end
endmodule

module tmr_quad_mode_chk #(
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic          tick,
  input logic [7:0]    ctl_q,
  input logic [7:0]    mode_q,
  input logic [7:0]    lo0,
  input logic [7:0]    hi0,
  input logic [7:0]    lo1,
  input logic [7:0]    hi1,
  input logic          set_f0,
  input logic          set_f1
);
  p_tick_gap_r4: assert property (@(posedge clk) disable iff (!rst_n) tick |=> !tick);

  p_run_cleared_r3: assert property (@(posedge clk)
    $past(!rst_n) |-> (ctl_q[6] == 1'b0 && ctl_q[4] == 1'b0));

  p_hold_stopped_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_q[4] && !ctl_q[6] && !wr_en) |=> $stable({lo0, hi0, lo1, hi1}));

  p_upper_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[1:0] == 2'b00 && !(wr_en && wr_addr == AW'(2))) |=> $stable(lo0[7:5]));

  p_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (set_f0 && mode_q[1:0] == 2'b10 && !wr_en) |=> (lo0 == hi0));

  p_ch1_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q[5:4] == 2'b11 && !wr_en) |=> $stable({lo1, hi1}));

  p_flag0_prio_r11: assert property (@(posedge clk) disable iff (!rst_n) set_f0 |=> ctl_q[5]);
  p_flag1_prio_r11: assert property (@(posedge clk) disable iff (!rst_n) set_f1 |=> ctl_q[7]);
endmodule

bind tmr_quad_mode tmr_quad_mode_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .tick(tick),
  .ctl_q(ctl_q), .mode_q(mode_q), .lo0(lo0), .hi0(hi0), .lo1(lo1), .hi1(hi1),
  .set_f0(set_f0), .set_f1(set_f1)
);

// File: tb/tmr_quad_mode_bench.sv
module tmr_quad_mode_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [2:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [1:0] ev_in = 2'b11;
  logic [1:0] gate_in = 2'b00;
  int checks = 0;
  int failures = 0;

  tmr_quad_mode u_tmr_quad_mode (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ev_in(ev_in), .gate_in(gate_in)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%02h expected=%02h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic expect_reg(input string tag, input logic [2:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic run_window(input logic [7:0] mask, input int k);
    logic [7:0] v;
    wr(3'd0, mask);
    repeat (12 * k - 1) @(posedge clk);
    @(negedge clk);
    rd_addr = 3'd0;
    #1 v = rd_data;
    wr_en = 1'b1; wr_addr = 3'd0; wr_data = v & ~mask;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic ev_pulse(input int c);
    @(negedge clk);
    ev_in[c] = 1'b0;
    repeat (4) @(negedge clk);
    ev_in[c] = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  function automatic logic [16:0] model(input int m, input logic [7:0] h0, input logic [7:0] l0,
                                        input int k);
    logic [7:0] h = h0;
    logic [7:0] l = l0;
    logic f = 1'b0;
    logic [12:0] v13;
    logic [15:0] v16;
    for (int i = 0; i < k; i++) begin
      if (m == 0) begin
        v13 = {h, l[4:0]};
        if (v13 == 13'h1FFF) f = 1'b1;
        v13 = v13 + 13'd1;
        h = v13[12:5];
        l[4:0] = v13[4:0];
      end else if (m == 1) begin
        v16 = {h, l};
        if (v16 == 16'hFFFF) f = 1'b1;
        v16 = v16 + 16'd1;
        {h, l} = v16;
      end else begin
        if (l == 8'hFF) begin
          f = 1'b1;
          l = h;
        end else l = l + 8'd1;
      end
    end
    return {f, h, l};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [16:0] e;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    for (int a = 0; a < 8; a++) expect_reg("R1 reset value", 3'(a), 8'h00);

    wr(3'd0, 8'h0A);
    expect_reg("R2 low control bits stored", 3'd0, 8'h0A);
    wr(3'd0, 8'h00);
    wr(3'd3, 8'h5C);
    expect_reg("R1 write readback", 3'd3, 8'h5C);
    repeat (30) @(posedge clk);
    expect_reg("R3 stopped count holds", 3'd3, 8'h5C);

    for (int c = 0; c < 2; c++) begin
      for (int m = 0; m < 3; m++) begin
        for (int di = 0; di < 3; di++) begin
          int d;
          logic [7:0] h, l;
          logic [12:0] v13;
          logic [15:0] v16;
          d = (di == 0) ? 1 : (di == 1) ? 6 : 40;
          if (m == 0) begin
            v13 = 13'(8192 - d);
            h = v13[12:5];
            l = {3'b101, v13[4:0]};
          end else if (m == 1) begin
            v16 = 16'(65536 - d);
            {h, l} = v16;
          end else begin
            l = 8'(256 - d);
            h = 8'(8'h40 + d);
          end
          wr(3'd1, 8'(m << (4 * c)));
          wr(3'(2 + 2 * c), l);
          wr(3'(3 + 2 * c), h);
          run_window(8'(8'h10 << (2 * c)), 8);
          e = model(m, h, l, 8);
          if (m == 0) begin
            expect_reg("R6 13-bit low", 3'(2 + 2 * c), e[7:0]);
            expect_reg("R6 13-bit high", 3'(3 + 2 * c), e[15:8]);
          end else if (m == 1) begin
            expect_reg("R7 16-bit low", 3'(2 + 2 * c), e[7:0]);
            expect_reg("R7 16-bit high", 3'(3 + 2 * c), e[15:8]);
          end else begin
            expect_reg("R8 reload low", 3'(2 + 2 * c), e[7:0]);
            expect_reg("R8 reload high", 3'(3 + 2 * c), e[15:8]);
          end
          rd(3'd0, v);
          chk("R4 tick rate and overflow flag", {7'd0, v[5 + 2 * c]}, {7'd0, e[16]});
        end
      end
    end

    wr(3'd0, 8'h00);
    expect_reg("R11 flag cleared by write", 3'd0, 8'h00);

    wr(3'd1, 8'h09);
    wr(3'd2, 8'h00);
    wr(3'd3, 8'h00);
    gate_in[0] = 1'b0;
    run_window(8'h10, 5);
    expect_reg("R3 gate low blocks count", 3'd2, 8'h00);
    gate_in[0] = 1'b1;
    run_window(8'h10, 5);
    expect_reg("R3 gate high allows count", 3'd2, 8'h05);

    wr(3'd1, 8'h60);
    wr(3'd4, 8'h00);
    wr(3'd5, 8'h00);
    wr(3'd0, 8'h40);
    for (int i = 0; i < 3; i++) ev_pulse(1);
    repeat (6) @(posedge clk);
    expect_reg("R5 event count", 3'd4, 8'h03);
    wr(3'd0, 8'h00);
    ev_pulse(1);
    repeat (6) @(posedge clk);
    expect_reg("R3 event ignored when stopped", 3'd4, 8'h03);

    wr(3'd1, 8'h13);
    wr(3'd2, 8'hFE);
    wr(3'd3, 8'h10);
    wr(3'd4, 8'hFE);
    wr(3'd5, 8'hFF);
    run_window(8'h50, 4);
    expect_reg("R9 split low", 3'd2, 8'h02);
    expect_reg("R9 split high", 3'd3, 8'h14);
    expect_reg("R10 channel 1 counts", 3'd4, 8'h02);
    expect_reg("R10 channel 1 counts high", 3'd5, 8'h00);
    expect_reg("R10 no channel 1 flag", 3'd0, 8'h20);
    wr(3'd3, 8'hFD);
    run_window(8'h40, 4);
    expect_reg("R9 high byte sets flag 1", 3'd0, 8'h80);
    expect_reg("R9 high byte wraps", 3'd3, 8'h01);
    expect_reg("R9 low holds without run 0", 3'd2, 8'h02);

    wr(3'd1, 8'h30);
    wr(3'd4, 8'h12);
    wr(3'd5, 8'h34);
    run_window(8'h40, 3);
    expect_reg("R10 mode 11 hold low", 3'd4, 8'h12);
    expect_reg("R10 mode 11 hold high", 3'd5, 8'h34);
    expect_reg("R10 mode 11 no flag", 3'd0, 8'h00);
    expect_reg("R2 mode readback", 3'd1, 8'h30);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule